// File: doc/BRIEF.md
# Shared-Bus Memory Read Sequencer

This block sits on the host side of a parallel byte-wide memory whose low address byte and read data travel over the same 8-bit bidirectional bus. The memory captures the low address byte when its latch strobe falls. A read therefore takes four phases. First the full address is presented while the strobe is high. Then the strobe drops and the low byte is held on the bus. The controller then releases the bus for a turnaround cycle. Finally output enable is asserted and the returned byte is captured.

A client raises `req` with a 16-bit address while `busy` is low. The controller runs the access and returns the byte on `rdata` with a single-cycle `rvalid` pulse. It then waits out the memory's output turn-off window before it accepts the next request. Every phase length is derived at elaboration from nanosecond timing parameters and the clock period parameter.

When nothing is pending, the controller parks the memory in standby: strobe high, output enable high, bus not driven.

Top module: `mad_read_ctrl`

## Requirements
- R1: Out of reset and whenever `busy` is low, `ale`=1, `oe_n`=1 and `ad_oe`=0, and no `rvalid` is produced.
- R2: A request accepted while idle drives `a_hi`=addr[15:8] and `ad_out`=addr[7:0] with `ad_oe`=1 in the first cycle. `ale` stays high with the address driven for max(ceil(T_ALE_W/T), ceil(T_AS/T)) cycles before it falls, and `ad_oe` is 1 at the cycle `ale` falls.
- R3: After `ale` falls, the low address byte stays driven for ceil(T_AH/T) cycles before `ad_oe` drops.
- R4: `ad_oe` and `oe_n`=0 are never active together, and `ad_oe` is 0 in the cycle before `oe_n` falls.
- R5: The read byte is sampled no earlier than T_ACC after the `ale` fall and no earlier than T_OE after the `oe_n` fall.
- R6: `rvalid` is a one-cycle pulse carrying the byte sampled from `ad_in`, and `rdata` holds that byte until the next capture.
- R7: After `oe_n` rises, `ad_oe` stays 0 for at least T_DF, and `busy` stays high until ceil(T_DF/T) cycles after the capture edge.
- R8: `req` and `addr` are ignored while `busy` is high: each accepted request yields exactly one `rvalid`, and that pulse carries the data of the accepted address.
- R9: `a_hi` holds the accepted upper address byte, unchanged, for the whole time `busy` is high.
- R10: Phase lengths are ceil(ns/T), and never less than 1. With SETUP, HOLD, DATA = max(ceil(T_ACC/T)-HOLD-1, ceil(T_OE/T), 1) and RECOV = ceil(T_DF/T), `rvalid` follows the accepting edge by SETUP+HOLD+1+DATA cycles and `busy` falls RECOV cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, sampled while idle |
| addr | input | 16 | Byte address of the request |
| busy | output | 1 | Access or recovery in progress |
| rdata | output | 8 | Last byte read |
| rvalid | output | 1 | One-cycle pulse when rdata is new |
| ale | output | 1 | Low-address latch strobe, captured on falling edge |
| oe_n | output | 1 | Memory output enable, active low |
| a_hi | output | 8 | Upper address byte pins |
| ad_out | output | 8 | Value driven onto the shared bus |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ad_in | input | 8 | Value read from the shared bus |

## Verification
The bench builds the controller with a 4 ns clock period and the default nanosecond limits. This gives phases of 12 setup, 4 hold, 13 data and 7 recovery cycles. At this setting the strobe width, not the address setup, sets the first phase, and the access time from the strobe fall, not the output-enable delay, sets the data phase. A cycle lost in either phase, or in recovery, therefore moves a limit past the behavioural memory model in the bench. That model returns a corrupted byte when a timing limit is missed and flags any drive overlap, so such a lost cycle shows up as wrong data, wrong latency or bus contention.

// File: rtl/mad_pkg.sv
package mad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_TURN  = 3'd3,
    ST_DATA  = 3'd4,
    ST_RECOV = 3'd5
  } mad_state_e;

  // Round a nanosecond limit up to whole clock cycles, at least one.
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mad_timer.sv
module mad_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/mad_seq.sv
module mad_seq
  import mad_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int SETUP_C = 1,
  parameter int HOLD_C  = 1,
  parameter int DATA_C  = 1,
  parameter int REC_C   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             expired,
  output mad_state_e       state,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture
);

  localparam logic [CNT_W-1:0] LV_SETUP = CNT_W'(SETUP_C - 1);
  localparam logic [CNT_W-1:0] LV_HOLD  = CNT_W'(HOLD_C - 1);
  localparam logic [CNT_W-1:0] LV_DATA  = CNT_W'(DATA_C - 1);
  localparam logic [CNT_W-1:0] LV_REC   = CNT_W'(REC_C - 1);

  mad_state_e state_q;
  mad_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d  = ST_ADDR;
          load     = 1'b1;
          load_val = LV_SETUP;
          accept   = 1'b1;
        end
      end
      ST_ADDR: begin
        if (expired) begin
          state_d  = ST_HOLD;
          load     = 1'b1;
          load_val = LV_HOLD;
        end
      end
      ST_HOLD: begin
        if (expired) begin
          state_d  = ST_TURN;
          load     = 1'b1;
          load_val = '0;
        end
      end
      ST_TURN: begin
        state_d  = ST_DATA;
        load     = 1'b1;
        load_val = LV_DATA;
      end
      ST_DATA: begin
        if (expired) begin
          state_d  = ST_RECOV;
          load     = 1'b1;
          load_val = LV_REC;
          capture  = 1'b1;
        end
      end
      ST_RECOV: begin
        if (expired) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R4: the data phase is only ever entered from the turnaround cycle
  a_r4_data_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> $past(state_q) == ST_TURN);

  // R8: a new access is only started from idle
  a_r8_accept_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && $past(state_q) != ST_ADDR) |-> $past(state_q) == ST_IDLE);

endmodule

// File: rtl/mad_capture.sv
module mad_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= ad_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R6: rvalid never lasts longer than one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q);

  // R6: rdata only changes alongside a new rvalid
  a_r6_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_q |-> $stable(rdata_q));

endmodule

// File: rtl/mad_read_ctrl.sv
module mad_read_ctrl
  import mad_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ALE_W_NS    = 45,
  parameter int T_AS_NS       = 15,
  parameter int T_AH_NS       = 15,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_DF_NS       = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [AW-1:0]    addr,
  output logic             busy,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             ale,
  output logic             oe_n,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in
);

  localparam int HW      = AW - DW;
  localparam int SETUP_C = max2(ns2cyc(T_ALE_W_NS, CLK_PERIOD_NS),
                                ns2cyc(T_AS_NS, CLK_PERIOD_NS));
  localparam int HOLD_C  = ns2cyc(T_AH_NS, CLK_PERIOD_NS);
  localparam int ACC_C   = ns2cyc(T_ACC_NS, CLK_PERIOD_NS);
  localparam int OE_C    = ns2cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int DATA_C  = max2(max2(ACC_C - HOLD_C - 1, OE_C), 1);
  localparam int REC_C   = ns2cyc(T_DF_NS, CLK_PERIOD_NS);
  localparam int MAX_C   = max2(max2(SETUP_C, HOLD_C), max2(DATA_C, REC_C));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mad_state_e       state;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             accept;
  logic             capture;
  logic             expired;

  mad_seq #(
    .CNT_W  (CNT_W),
    .SETUP_C(SETUP_C),
    .HOLD_C (HOLD_C),
    .DATA_C (DATA_C),
    .REC_C  (REC_C)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .req     (req),
    .expired (expired),
    .state   (state),
    .load    (load),
    .load_val(load_val),
    .accept  (accept),
    .capture (capture)
  );

  mad_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  mad_capture #(
    .DW(DW)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .capture(capture),
    .ad_in  (ad_in),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  // Accepted address, loaded only when a request is taken
  logic [AW-1:0] adr_q;
  logic [AW-1:0] adr_d;

  always_comb begin
    adr_d = adr_q;
    if (accept) begin
      adr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      adr_q <= '0;
    end else begin
      adr_q <= adr_d;
    end
  end

  // Pin decode from the registered phase
  always_comb begin
    ale   = (state == ST_IDLE) || (state == ST_ADDR);
    ad_oe = (state == ST_ADDR) || (state == ST_HOLD);
    oe_n  = (state != ST_DATA);
    busy  = (state != ST_IDLE);
  end

  assign a_hi   = adr_q[AW-1:DW];
  assign ad_out = adr_q[DW-1:0];

  // R1: idle parks the memory in standby with the bus released
  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> (ale && oe_n && !ad_oe && !rvalid));

  // R4: no bus drive while the memory output is enabled
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(ad_oe && !oe_n));

  // R4: one released cycle before output enable falls
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(oe_n) |-> !$past(ad_oe));

  // R2: the latch strobe only falls while the low byte is driven
  a_r2_fall_with_addr: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(ale) |-> ad_oe);

  // R9: upper address pins stay put during an access
  a_r9_hi_stable: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy && $past(busy)) |-> $stable(a_hi));

  // R7: the bus is not driven in the cycle right after output enable rises
  a_r7_no_drive_after_oe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(oe_n) |=> !ad_oe);

endmodule

// File: tb/mad_read_ctrl_bench.sv
module mad_read_ctrl_bench;

  localparam int P     = 4;
  localparam int TALEW = 45;
  localparam int TAS   = 15;
  localparam int TAH   = 15;
  localparam int TACC  = 70;
  localparam int TOE   = 35;
  localparam int TDF   = 25;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic [15:0] addr;
  logic       busy;
  logic [7:0] rdata;
  logic       rvalid;
  logic       ale;
  logic       oe_n;
  logic [7:0] a_hi;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [7:0] ad_in;

  int n_checks;
  int n_fail;
  int n_rvalid;
  int n_reads;

  mad_read_ctrl #(
    .CLK_PERIOD_NS(P),
    .T_ALE_W_NS(TALEW), .T_AS_NS(TAS), .T_AH_NS(TAH),
    .T_ACC_NS(TACC), .T_OE_NS(TOE), .T_DF_NS(TDF)
  ) u_mad_read_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
    .rdata(rdata), .rvalid(rvalid), .ale(ale), .oe_n(oe_n), .a_hi(a_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [7:0] mem(input logic [7:0] hi, input logic [7:0] lo);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'h3C;
  endfunction

  function automatic int exp_lat();
    int s, h, d;
    s = (cyc(TALEW) > cyc(TAS)) ? cyc(TALEW) : cyc(TAS);
    h = cyc(TAH);
    d = cyc(TACC) - h - 1;
    if (cyc(TOE) > d) d = cyc(TOE);
    if (d < 1) d = 1;
    return s + h + 1 + d;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Memory model and bus-timing monitor
  logic [7:0] cur_hi, cur_lo, lat_lo;
  bit prev_ale, prev_oen, prev_adoe, draining;
  int ale_run, adr_run, hold_run, cnt_f, cnt_o, df_k;

  initial begin
    ad_in = 8'h00; prev_ale = 1; prev_oen = 1; prev_adoe = 0; draining = 0;
    ale_run = 0; adr_run = 0; hold_run = 0; cnt_f = 0; cnt_o = 0; df_k = 0;
    lat_lo = 8'h00; cur_hi = 8'h00; cur_lo = 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) n_rvalid++;
      if (busy && (a_hi != cur_hi)) chk(0, "R9", a_hi, cur_hi);
      if (ad_oe && !oe_n) chk(0, "R4 overlap", 1, 0);
      if (prev_ale && !ale) begin
        chk(ale_run * P >= TALEW, "R2 strobe width", ale_run, cyc(TALEW));
        chk(ad_oe && ad_out == cur_lo && adr_run * P >= TAS, "R2 setup", adr_run, cyc(TAS));
        lat_lo = ad_out; cnt_f = 1; hold_run = 1; ale_run = 0;
      end else begin
        cnt_f++;
        if (!ale && ad_oe) hold_run++;
      end
      if (ale) ale_run++;
      if (ale && ad_oe && ad_out == cur_lo) adr_run++;
      else if (!ad_oe) adr_run = 0;
      if (prev_adoe && !ad_oe && !ale) chk(hold_run * P >= TAH, "R3 hold", hold_run, cyc(TAH));
      if (prev_oen && !oe_n) begin
        chk(!prev_adoe, "R4 turnaround", prev_adoe, 0);
        cnt_o = 1;
      end else if (!oe_n) cnt_o++;
      if (!prev_oen && oe_n) begin
        draining = 1; df_k = 0;
      end else if (draining) begin
        df_k++;
        if (df_k * P >= TDF) draining = 0;
      end
      if (draining && ad_oe) chk(0, "R7 drive during turn-off", df_k, cyc(TDF));
      if (!oe_n && cnt_f * P >= TACC && cnt_o * P >= TOE) ad_in = mem(a_hi, lat_lo);
      else ad_in = ~mem(a_hi, lat_lo);
      prev_ale = ale; prev_oen = oe_n; prev_adoe = ad_oe;
    end
  end

  task automatic do_read(input logic [15:0] a, input int gap, input bit poke);
    int k;
    logic [7:0] e;
    for (int g = 0; g < gap; g++) @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; addr = a; cur_hi = a[15:8]; cur_lo = a[7:0];
    @(negedge clk);
    req = 1'b0;
    k = 0;
    chk(busy && ale && ad_oe && ad_out == a[7:0] && a_hi == a[15:8], "R2 address phase",
        {busy, ale, ad_oe, ad_out, a_hi}, {3'b111, a[7:0], a[15:8]});
    if (poke) begin
      req = 1'b1; addr = ~a;
    end
    while (!rvalid && k < 200) begin
      @(negedge clk);
      k++;
      if (poke && k == 5) req = 1'b0;
    end
    n_reads++;
    e = mem(a[15:8], a[7:0]);
    chk(k == exp_lat(), "R5 R10 latency", k, exp_lat());
    chk(rdata == e, poke ? "R8 data of accepted address" : "R6 data", rdata, e);
    @(negedge clk); k++;
    chk(!rvalid && rdata == e, "R6 pulse and hold", {rvalid, rdata}, {1'b0, e});
    while (busy && k < 300) begin
      @(negedge clk); k++;
    end
    chk(k == exp_lat() + cyc(TDF), "R7 R10 recovery", k, exp_lat() + cyc(TDF));
    chk(ale && oe_n && !ad_oe, "R1 standby after access", {ale, oe_n, ad_oe}, 3'b110);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; n_rvalid = 0; n_reads = 0;
    req = 1'b0; addr = 16'h0000; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ale && oe_n && !ad_oe && !busy && !rvalid, "R1 reset state",
        {ale, oe_n, ad_oe, busy, rvalid}, 5'b11000);
    do_read(16'h0000, 0, 0);
    do_read(16'hFFFF, 0, 0);
    do_read(16'h5555, 3, 0);
    do_read(16'h2AAA, 0, 0);
    do_read(16'h00FF, 1, 0);
    do_read(16'hFF00, 0, 0);
    do_read(16'h1234, 0, 1);
    do_read(16'hA5C3, 2, 1);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) begin
      do_read(16'($urandom()), int'($urandom_range(0, 4)), bit'($urandom_range(0, 1)));
    end
    repeat (10) @(negedge clk);
    chk(n_rvalid == n_reads, "R8 one pulse per accepted request", n_rvalid, n_reads);
    chk(!busy && !rvalid, "R1 idle at end", {busy, rvalid}, 2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule